// File: doc/BRIEF.md
# Quadword Refill FIFO

This block buffers 128-bit quadwords between a DMA channel that fills it and a decoder core that drains it. Eight entries are held, each as four 32-bit words addressed by word pointers that step by four and wrap at the end of storage. The producer opens a burst by naming how many quadwords it wants to send. The block grants only as many as fit at that moment, takes them one per clock, and reports the granted total once the last one has landed. A burst that is refused completely because the buffer is full raises a one-cycle interrupt.

The consumer asks for data by holding `out_ready`. While entries are present the oldest one is offered with `out_valid`, and a handshake removes it and clears its slot. If the consumer asks while the buffer holds fewer than half its entries, a level refill request goes to the DMA side. If it asks while the buffer is empty, a miss is flagged and nothing moves. A synchronous clear empties storage, pointers, count and any open burst. Both streams follow valid/ready rules. A beat transfers only on a clock edge where valid and ready are both high. `in_ready` is high only while granted beats remain. `out_valid` is high whenever the count is nonzero, and it never depends on `out_ready`. The depth must be a power of two.

Top module: `qfifo_refill`

## Requirements
- R1: After reset or after a cycle with `clr` high, `occupancy` is 0, `out_valid` is 0 and `in_ready` is 0. An open burst is dropped and reports no `burst_done`.
- R2: A `burst_start` with `burst_len` = N > 0 while no burst is open grants min(N, DEPTH − occupancy) quadwords. The beats are stored in arrival order, and each one raises `occupancy` by one.
- R3: `in_ready` is high from the cycle after the grant until the last granted beat is taken. `burst_done` pulses for one cycle in the cycle after that last beat, with `burst_count` equal to the grant.
- R4: If a burst with N > 0 is granted zero beats, `burst_done` pulses with `burst_count` = 0 in the cycle after the start, and `proc_irq` pulses in that same cycle.
- R5: While `occupancy` > 0, `out_valid` is high and `out_data` is the oldest stored quadword, with word k in bits [32k+31:32k]. A handshake lowers `occupancy` by one and exposes the next entry.
- R6: When `out_ready` is high while `occupancy` is 0, `read_miss` is high and `out_valid` is low. Occupancy and pointers stay unchanged, so the next quadword written is the next one read.
- R7: `refill_req` is high exactly when `out_ready` is high and `occupancy` < DEPTH/2.
- R8: When an input beat and an output handshake happen in the same cycle, `occupancy` stays the same and the FIFO order is kept.
- R9: A `burst_start` while a burst is open is ignored. The open burst's grant and done report are unchanged.
- R10: A `burst_start` with N = 0 is ignored: no `burst_done`, no `proc_irq` and no change of `occupancy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of storage, pointers, count and open burst |
| burst_start | input | 1 | Opens a burst request |
| burst_len | input | LEN_W | Requested number of quadwords |
| in_valid | input | 1 | Input quadword valid |
| in_ready | output | 1 | Granted beats remain |
| in_data | input | QW_W | Input quadword |
| burst_done | output | 1 | One-cycle pulse at burst end |
| burst_count | output | CNT_W | Quadwords granted to the finished burst |
| proc_irq | output | 1 | One-cycle pulse when a burst is fully refused |
| out_valid | output | 1 | Output quadword available |
| out_ready | input | 1 | Consumer read attempt |
| out_data | output | QW_W | Oldest quadword |
| read_miss | output | 1 | Read attempt while empty |
| refill_req | output | 1 | Read attempt while below half full |
| occupancy | output | CNT_W | Stored quadword count, 0 to DEPTH |

## Verification
The bench builds the block with its default parameters: 8 entries, 32-bit words, four words per quadword and an 8-bit length field. An 8-bit length can ask for more quadwords than the buffer holds, so the partial grant (10 asked for, 6 granted) and the full refusal can both be reached. Eight entries keep every occupancy level from empty to full within a few dozen cycles, including the edge where the refill request drops at four entries. The bench also drives the pointers across their wrap point before the simultaneous and clear scenarios.

// File: rtl/qfifo_pkg.sv
`timescale 1ns/1ps
package qfifo_pkg;
  // width of a counter able to hold 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

  // burst tracker state
  typedef struct packed {
    logic busy;
    logic done;
    logic irq;
  } burst_flags_t;
endpackage

// File: rtl/qfifo_store.sv
`timescale 1ns/1ps
module qfifo_store #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WPQ    = 4,
  localparam int unsigned NWORDS = DEPTH * WPQ,
  localparam int unsigned WPTR_W = $clog2(NWORDS),
  localparam int unsigned QW_W   = WORD_W * WPQ
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [WPTR_W-1:0] wr_wptr,
  input  logic [QW_W-1:0]   wr_data,
  input  logic              rd_en,
  input  logic [WPTR_W-1:0] rd_wptr,
  output logic [QW_W-1:0]   rd_data
);
  logic [WORD_W-1:0] mem [NWORDS];

  // word i belongs to slot i/WPQ; a popped slot is zeroed, a write wins a tie
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < NWORDS; i++) begin
        if (rd_en && rd_wptr == WPTR_W'((i / WPQ) * WPQ))
          mem[i] <= '0;
        if (wr_en && wr_wptr == WPTR_W'((i / WPQ) * WPQ))
          mem[i] <= wr_data[(i % WPQ)*WORD_W +: WORD_W];
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WPQ; w++)
      rd_data[w*WORD_W +: WORD_W] = mem[WPTR_W'(rd_wptr + WPTR_W'(w))];
  end
endmodule

// File: rtl/qfifo_ptrs.sv
`timescale 1ns/1ps
module qfifo_ptrs #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WPQ   = 4,
  localparam int unsigned WPTR_W = $clog2(DEPTH * WPQ),
  localparam int unsigned CNT_W  = qfifo_pkg::cnt_width(DEPTH),
  localparam int unsigned HALF   = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic              rd_try,
  output logic              pop,
  output logic [WPTR_W-1:0] wr_wptr,
  output logic [WPTR_W-1:0] rd_wptr,
  output logic [CNT_W-1:0]  count,
  output logic              not_empty,
  output logic              miss,
  output logic              refill
);
  assign not_empty = (count != '0);
  assign pop       = rd_try && not_empty;
  assign miss      = rd_try && !not_empty;
  assign refill    = rd_try && (count < CNT_W'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_wptr <= '0;
      rd_wptr <= '0;
      count   <= '0;
    end else if (clr) begin
      wr_wptr <= '0;
      rd_wptr <= '0;
      count   <= '0;
    end else begin
      if (push) wr_wptr <= WPTR_W'(wr_wptr + WPTR_W'(WPQ));
      if (pop)  rd_wptr <= WPTR_W'(rd_wptr + WPTR_W'(WPQ));
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R2
  AST_MISS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !push && !clr) |=> (count == '0) && $stable(rd_wptr)); // R6
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr) |=> count == $past(count) + 1'b1); // R2
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !clr) |=> $stable(count)); // R8
endmodule

// File: rtl/qfifo_burst.sv
`timescale 1ns/1ps
module qfifo_burst #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LEN_W = 8,
  localparam int unsigned CNT_W = qfifo_pkg::cnt_width(DEPTH),
  localparam int unsigned MW    = (LEN_W > CNT_W) ? LEN_W : CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic [CNT_W-1:0] count,
  input  logic             beat,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] done_cnt,
  output logic             irq
);
  import qfifo_pkg::*;

  burst_flags_t     fl;
  logic [CNT_W-1:0] remain, grant_q;
  logic [MW-1:0]    free_m, len_m, grant_m;

  assign free_m  = MW'(DEPTH) - MW'(count);
  assign len_m   = MW'(len);
  assign grant_m = (len_m > free_m) ? free_m : len_m;

  assign busy = fl.busy;
  assign done = fl.done;
  assign irq  = fl.irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl       <= '0;
      remain   <= '0;
      grant_q  <= '0;
      done_cnt <= '0;
    end else if (clr) begin
      fl     <= '0;
      remain <= '0;
    end else begin
      fl.done <= 1'b0;
      fl.irq  <= 1'b0;
      if (fl.busy) begin
        if (beat) begin
          remain <= remain - 1'b1;
          if (remain == CNT_W'(1)) begin
            fl.busy  <= 1'b0;
            fl.done  <= 1'b1;
            done_cnt <= grant_q;
          end
        end
      end else if (start && len != '0) begin
        if (grant_m == '0) begin
          fl.done  <= 1'b1;
          fl.irq   <= 1'b1;
          done_cnt <= '0;
        end else begin
          fl.busy <= 1'b1;
          remain  <= CNT_W'(grant_m);
          grant_q <= CNT_W'(grant_m);
        end
      end
    end
  end

  AST_READY_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> count < CNT_W'(DEPTH)); // R2
  AST_IRQ_ON_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && done_cnt == '0)); // R4
  AST_DONE_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_cnt != '0) |-> $fell(busy)); // R3
  AST_NO_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len == '0 && !busy) |=> !done && !busy); // R10
endmodule

// File: rtl/qfifo_refill.sv
`timescale 1ns/1ps
module qfifo_refill #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WPQ    = 4,
  parameter int unsigned LEN_W  = 8,
  localparam int unsigned QW_W   = WORD_W * WPQ,
  localparam int unsigned CNT_W  = qfifo_pkg::cnt_width(DEPTH),
  localparam int unsigned WPTR_W = $clog2(DEPTH * WPQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             burst_start,
  input  logic [LEN_W-1:0] burst_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [QW_W-1:0]  in_data,
  output logic             burst_done,
  output logic [CNT_W-1:0] burst_count,
  output logic             proc_irq,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [QW_W-1:0]  out_data,
  output logic             read_miss,
  output logic             refill_req,
  output logic [CNT_W-1:0] occupancy
);
  logic              push, pop;
  logic [WPTR_W-1:0] wr_wptr, rd_wptr;

  assign push = in_valid && in_ready;

  qfifo_burst #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .start(burst_start), .len(burst_len), .count(occupancy), .beat(push),
    .busy(in_ready), .done(burst_done), .done_cnt(burst_count), .irq(proc_irq)
  );

  qfifo_ptrs #(.DEPTH(DEPTH), .WPQ(WPQ)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(push), .rd_try(out_ready), .pop(pop),
    .wr_wptr(wr_wptr), .rd_wptr(rd_wptr), .count(occupancy),
    .not_empty(out_valid), .miss(read_miss), .refill(refill_req)
  );

  qfifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .WPQ(WPQ)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(push), .wr_wptr(wr_wptr), .wr_data(in_data),
    .rd_en(pop), .rd_wptr(rd_wptr), .rd_data(out_data)
  );

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (occupancy == '0) && !in_ready && !burst_done); // R1
endmodule

// File: tb/test_qfifo_refill.sv
`timescale 1ns/1ps
module test_qfifo_refill;
  localparam int DEPTH = 8, WORD_W = 32, WPQ = 4, LEN_W = 8;
  localparam int QW_W = WORD_W * WPQ, CNT_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, clr = 0;
  logic burst_start = 0, in_valid = 0, out_ready = 0;
  logic [LEN_W-1:0] burst_len = '0;
  logic [QW_W-1:0] in_data = '0;
  logic in_ready, burst_done, proc_irq, out_valid, read_miss, refill_req;
  logic [CNT_W-1:0] burst_count, occupancy;
  logic [QW_W-1:0] out_data;

  int checks = 0, fails = 0;
  logic [QW_W-1:0] model[$];

  always #5 clk = ~clk;

  qfifo_refill #(.DEPTH(DEPTH), .WORD_W(WORD_W), .WPQ(WPQ), .LEN_W(LEN_W)) i_qfifo_refill (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .burst_start(burst_start), .burst_len(burst_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .burst_done(burst_done), .burst_count(burst_count), .proc_irq(proc_irq),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .read_miss(read_miss), .refill_req(refill_req), .occupancy(occupancy)
  );

  task automatic chk(input string req, input string what, input logic [QW_W-1:0] act, input logic [QW_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [QW_W-1:0] mk(input int v);
    return {32'(v + 3), 32'(v + 2), 32'(v + 1), 32'(v)};
  endfunction

  // request n, expect a grant of g; finishes at a negedge right after done is due
  task automatic do_burst(input int n, input int g, input int base);
    @(negedge clk); burst_start = 1; burst_len = LEN_W'(n);
    @(posedge clk); @(negedge clk); burst_start = 0;
    for (int k = 0; k < g; k++) begin
      in_valid = 1; in_data = mk(base + 16*k);
      chk("R3", "in_ready during burst", in_ready, 1);
      if (!in_ready) break;
      model.push_back(mk(base + 16*k));
      @(posedge clk); @(negedge clk);
    end
    in_valid = 0;
    chk("R3", "burst_done", burst_done, 1);
    chk("R3", "burst_count", burst_count, QW_W'(g));
    chk("R3", "in_ready after burst", in_ready, 0);
    chk("R4", "proc_irq", proc_irq, (g == 0) ? 1 : 0);
    chk("R2", "occupancy after burst", occupancy, QW_W'(model.size()));
  endtask

  task automatic pop_one();
    @(negedge clk); out_ready = 1; #1;
    chk("R7", "refill_req", refill_req, (model.size() < DEPTH/2) ? 1 : 0);
    if (model.size() == 0) begin
      chk("R6", "read_miss", read_miss, 1);
      chk("R6", "out_valid when empty", out_valid, 0);
    end else begin
      chk("R5", "out_valid", out_valid, 1);
      chk("R5", "out_data", out_data, model[0]);
      chk("R6", "read_miss when data", read_miss, 0);
      void'(model.pop_front());
    end
    @(posedge clk); @(negedge clk); out_ready = 0; #1;
    chk("R5", "occupancy after read", occupancy, QW_W'(model.size()));
    chk("R7", "refill_req idle", refill_req, 0);
  endtask

  task automatic t_reset();
    chk("R1", "reset occupancy", occupancy, 0);
    chk("R1", "reset out_valid", out_valid, 0);
    chk("R1", "reset in_ready", in_ready, 0);
  endtask

  task automatic t_zero_len();
    @(negedge clk); burst_start = 1; burst_len = '0;
    @(posedge clk); @(negedge clk); burst_start = 0;
    chk("R10", "zero-length done", burst_done, 0);
    chk("R10", "zero-length irq", proc_irq, 0);
    chk("R10", "zero-length in_ready", in_ready, 0);
    chk("R10", "zero-length occupancy", occupancy, QW_W'(model.size()));
  endtask

  task automatic t_both();
    @(negedge clk); burst_start = 1; burst_len = LEN_W'(1);
    @(posedge clk); @(negedge clk); burst_start = 0;
    in_valid = 1; in_data = mk('h700); out_ready = 1; #1;
    chk("R8", "out_data in dual cycle", out_data, model[0]);
    void'(model.pop_front()); model.push_back(mk('h700));
    @(posedge clk); @(negedge clk); in_valid = 0; out_ready = 0; #1;
    chk("R8", "occupancy held", occupancy, QW_W'(model.size()));
    chk("R8", "done after dual", burst_done, 1);
    while (model.size() > 0) pop_one();
  endtask

  task automatic t_busy_start();
    @(negedge clk); burst_start = 1; burst_len = LEN_W'(2);
    @(posedge clk); @(negedge clk); burst_len = LEN_W'(5);
    @(posedge clk); @(negedge clk); burst_start = 0;
    for (int k = 0; k < 2; k++) begin
      in_valid = 1; in_data = mk('h800 + k);
      model.push_back(mk('h800 + k));
      @(posedge clk); @(negedge clk);
    end
    in_valid = 0;
    chk("R9", "done after busy start", burst_done, 1);
    chk("R9", "count ignores second start", burst_count, 2);
    chk("R9", "in_ready closed", in_ready, 0);
  endtask

  task automatic t_clear();
    @(negedge clk); burst_start = 1; burst_len = LEN_W'(3);
    @(posedge clk); @(negedge clk); burst_start = 0;
    in_valid = 1; in_data = mk('h900);
    @(posedge clk); @(negedge clk); in_valid = 0; clr = 1;
    @(posedge clk); @(negedge clk); clr = 0; model.delete();
    chk("R1", "clear occupancy", occupancy, 0);
    chk("R1", "clear in_ready", in_ready, 0);
    chk("R1", "clear out_valid", out_valid, 0);
    @(posedge clk); @(negedge clk);
    chk("R1", "no done after clear", burst_done, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    do_burst(3, 3, 'h100);
    pop_one();
    do_burst(10, 6, 'h200);
    do_burst(1, 0, 'h300);
    t_zero_len();
    for (int i = 0; i < DEPTH; i++) pop_one();
    pop_one();
    do_burst(2, 2, 'h400);
    pop_one(); pop_one();
    do_burst(5, 5, 'h500);
    t_both();
    t_busy_start();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule